// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front End

This block is the software-facing control layer of a multi-channel descriptor DMA. A 32-bit register port reaches one control window per channel. Each window holds that channel's configuration, command, saved-pointer, interrupt-mask and stream-command registers. The block decodes every access into a channel and a register. It keeps a three-state run machine for each channel and accumulates raw interrupt events reported by the transfer engines. It drives one level interrupt line per channel.

The transfer engines that move data sit outside this block. They report whether a client is attached to the channel, whether the current descriptor is flagged end-of-list, when the channel reaches the end of its list, and which interrupt causes occurred. The block returns single-cycle strobes to them: start, continue, load data descriptor and load context. Each strobe comes one cycle after the register write that caused it.

Top module: `dma_regfront`

## Requirements
- R1: A word access addresses channel `busAddr[ADDR_W-1:13]` and register `busAddr[7:2]`. The register byte offsets are: configuration 0x00, command 0x04, status 0x08, saved descriptor pointer 0x0C, saved buffer pointer 0x10, interrupt mask 0x14, interrupt acknowledge 0x18, raw interrupts 0x1C, masked interrupts 0x20, stream command 0x24. Both saved pointers read back the last value written, and each channel keeps its own copy. Any other register index reads as zero.
- R2: After reset, every channel is in the reset state and all registers read zero apart from status, which reads 0x1. All interrupt lines, all strobes and `errFlag` are low.
- R3: A configuration write with bit 0 (enable) clear puts the channel in the reset state. Otherwise, bit 1 (stop) set puts it in the stopped state. Otherwise the state is left unchanged. Reset wins when both conditions apply.
- R4: Status reads the one-hot state in bits 2:0 (reset=1, stopped=2, running=4), the end-of-list flag in bit 5, and the channel's `cmdSrc` value from bit 8 upward. All other bits read zero.
- R5: A pulse on an `intrSet` bit sets that raw interrupt bit. Writing ones to the acknowledge register clears the matching raw bits, but a set in the same cycle wins. The acknowledge register always reads zero.
- R6: The masked interrupt register reads raw AND mask. A channel's interrupt line is high exactly when its masked value is non-zero.
- R7: A stream-command write stores its low 10 bits. Bit 0 pulses `loadDescStb` and bit 2 pulses `loadCtxStb`. Bits 0 and 1 together with a client attached pulse `startStb`, move the channel to running and clear its end-of-list flag. Without a client, no start occurs.
- R8: A command write with bit 0 set pulses `contStb` and clears the end-of-list flag only when all of these hold: enable is set, a client is attached, stop is clear, the channel is running, `descEol` is high, and the end-of-list flag is set.
- R9: A pulse on `eolHit` sets the channel's end-of-list flag.
- R10: An access whose `busSize` is not 2'b10 (32-bit) changes no register, reads as zero, and sets the sticky `errFlag`.
- R11: An access to a channel index at or above NCH reads as zero and changes nothing, and does not set `errFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busSize | input | 2 | Access width code, 2'b10 = 32 bits |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| errFlag | output | 1 | Sticky flag for accesses of the wrong width |
| hasClient | input | NCH | Client attached, per channel |
| descEol | input | NCH | Current descriptor carries end-of-list |
| eolHit | input | NCH | Engine reached end of list (pulse) |
| intrSet | input | NCH*INTR_W | Raw interrupt set pulses, channel-major |
| cmdSrc | input | NCH*SRC_W | Command source value shown in status |
| chanIrq | output | NCH | Interrupt line per channel |
| startStb | output | NCH | Start the channel's engine |
| contStb | output | NCH | Continue after end of list |
| loadDescStb | output | NCH | Fetch the data descriptor |
| loadCtxStb | output | NCH | Fetch the context descriptor |

## Verification
The bench builds the block with NCH=3 and the default ADDR_W=16, so the address holds eight channel windows and only three are populated. Indices 3 and 7 therefore exercise the out-of-range path, while three real channels show that writes stay within their own window. With INTR_W=4 and SRC_W=4, the interrupt set/acknowledge race and the command-source field in status bits 11:8 can be checked against exact values.

// File: rtl/dma_regfront_pkg.sv
package dma_regfront_pkg;

  localparam int REG_IDX_W = 6;
  localparam int STREAM_W  = 10;

  localparam logic [REG_IDX_W-1:0] RI_CFG        = 6'd0;
  localparam logic [REG_IDX_W-1:0] RI_CMD        = 6'd1;
  localparam logic [REG_IDX_W-1:0] RI_STATUS     = 6'd2;
  localparam logic [REG_IDX_W-1:0] RI_SAVED_DESC = 6'd3;
  localparam logic [REG_IDX_W-1:0] RI_SAVED_BUF  = 6'd4;
  localparam logic [REG_IDX_W-1:0] RI_MASK       = 6'd5;
  localparam logic [REG_IDX_W-1:0] RI_ACK        = 6'd6;
  localparam logic [REG_IDX_W-1:0] RI_RAW        = 6'd7;
  localparam logic [REG_IDX_W-1:0] RI_MASKED     = 6'd8;
  localparam logic [REG_IDX_W-1:0] RI_STREAM     = 6'd9;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  // stream command bit positions
  localparam int SC_LOAD_DESC = 0;
  localparam int SC_BURST     = 1;
  localparam int SC_LOAD_CTX  = 2;

  typedef enum logic [2:0] {
    ST_RESET   = 3'b001,
    ST_STOPPED = 3'b010,
    ST_RUNNING = 3'b100
  } chState_e;

  // write strobes from the decoder, gated per channel by its hit bit
  typedef struct packed {
    logic wrCfg;
    logic wrCmd;
    logic wrSavedDesc;
    logic wrSavedBuf;
    logic wrMask;
    logic wrAck;
    logic wrStream;
  } wrStrobe_t;

endpackage

// File: rtl/dma_regfront_ctrl.sv
module dma_regfront_ctrl
  import dma_regfront_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  output wrStrobe_t            wrStb,
  output logic [NCH-1:0]       chanHit,
  output logic [REG_IDX_W-1:0] regIdx,
  output logic [ADDR_W-14:0]   chanIdx,
  output logic                 rdEn,
  output logic                 errFlag
);

  localparam int CH_W = ADDR_W - 13;
  localparam logic [CH_W:0] NCH_L = (CH_W+1)'(NCH);

  logic wordOk, inRange, wrAcc;
  logic unusedAddr;

  assign unusedAddr = ^{busAddr[12:8], busAddr[1:0]};
  assign chanIdx    = busAddr[ADDR_W-1:13];
  assign regIdx     = busAddr[7:2];
  assign wordOk     = (busSize == SIZE_WORD);
  assign inRange    = ({1'b0, chanIdx} < NCH_L);
  assign wrAcc      = busValid & busWrite & wordOk & inRange;
  assign rdEn       = busValid & ~busWrite & wordOk & inRange;

  always_comb begin
    wrStb             = '0;
    wrStb.wrCfg       = wrAcc && (regIdx == RI_CFG);
    wrStb.wrCmd       = wrAcc && (regIdx == RI_CMD);
    wrStb.wrSavedDesc = wrAcc && (regIdx == RI_SAVED_DESC);
    wrStb.wrSavedBuf  = wrAcc && (regIdx == RI_SAVED_BUF);
    wrStb.wrMask      = wrAcc && (regIdx == RI_MASK);
    wrStb.wrAck       = wrAcc && (regIdx == RI_ACK);
    wrStb.wrStream    = wrAcc && (regIdx == RI_STREAM);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign chanHit[i] = wrAcc && (chanIdx == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        errFlag <= 1'b0;
    else if (busValid && !wordOk)     errFlag <= 1'b1;
  end

endmodule

// File: rtl/dma_regfront_chan.sv
module dma_regfront_chan
  import dma_regfront_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int INTR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sel,
  input  wrStrobe_t            wrStb,
  input  logic [31:0]          wdata,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic                 hasClient,
  input  logic                 descEol,
  input  logic                 eolHit,
  input  logic [INTR_W-1:0]    intrSet,
  input  logic [SRC_W-1:0]     cmdSrc,
  output logic [31:0]          rdData,
  output logic                 irq,
  output logic                 startStb,
  output logic                 contStb,
  output logic                 loadDescStb,
  output logic                 loadCtxStb,
  output logic [2:0]           chState
);

  logic [31:0]         cfgReg, cmdReg, savedDesc, savedBuf;
  logic [INTR_W-1:0]   maskReg, rawIntr, rawNext, ackBits;
  logic [STREAM_W-1:0] streamReg;
  logic                eolFlag;
  chState_e            stateQ, stateNext;

  logic doCfg, doCmd, doStream, doAck;
  logic scLoadD, scCtx, doStart, doCont, enabled;

  assign doCfg    = sel & wrStb.wrCfg;
  assign doCmd    = sel & wrStb.wrCmd;
  assign doStream = sel & wrStb.wrStream;
  assign doAck    = sel & wrStb.wrAck;

  assign scLoadD  = doStream & wdata[SC_LOAD_DESC];
  assign scCtx    = doStream & wdata[SC_LOAD_CTX];
  assign doStart  = scLoadD & wdata[SC_BURST] & hasClient;
  assign enabled  = cfgReg[0] & hasClient;
  assign doCont   = doCmd & wdata[0] & enabled & ~cfgReg[1]
                  & (stateQ == ST_RUNNING) & descEol & eolFlag;

  assign ackBits  = doAck ? wdata[INTR_W-1:0] : '0;
  assign rawNext  = (rawIntr & ~ackBits) | intrSet;

  always_comb begin
    stateNext = stateQ;
    if (doCfg) begin
      if (!wdata[0])     stateNext = ST_RESET;
      else if (wdata[1]) stateNext = ST_STOPPED;
    end else if (doStart) begin
      stateNext = ST_RUNNING;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg      <= '0;
      cmdReg      <= '0;
      savedDesc   <= '0;
      savedBuf    <= '0;
      maskReg     <= '0;
      rawIntr     <= '0;
      streamReg   <= '0;
      eolFlag     <= 1'b0;
      stateQ      <= ST_RESET;
      startStb    <= 1'b0;
      contStb     <= 1'b0;
      loadDescStb <= 1'b0;
      loadCtxStb  <= 1'b0;
    end else begin
      if (doCfg)                           cfgReg    <= wdata;
      if (doCmd)                           cmdReg    <= wdata;
      if (sel && wrStb.wrSavedDesc)        savedDesc <= wdata;
      if (sel && wrStb.wrSavedBuf)         savedBuf  <= wdata;
      if (sel && wrStb.wrMask)             maskReg   <= wdata[INTR_W-1:0];
      if (doStream)                        streamReg <= wdata[STREAM_W-1:0];
      rawIntr <= rawNext;
      stateQ  <= stateNext;
      if (doStart || doCont)               eolFlag   <= 1'b0;
      else if (eolHit)                     eolFlag   <= 1'b1;
      startStb    <= doStart;
      contStb     <= doCont;
      loadDescStb <= scLoadD;
      loadCtxStb  <= scCtx;
    end
  end

  always_comb begin
    unique case (regIdx)
      RI_CFG:        rdData = cfgReg;
      RI_CMD:        rdData = cmdReg;
      RI_STATUS:     rdData = (32'(cmdSrc) << 8) | (32'(eolFlag) << 5) | 32'(stateQ);
      RI_SAVED_DESC: rdData = savedDesc;
      RI_SAVED_BUF:  rdData = savedBuf;
      RI_MASK:       rdData = 32'(maskReg);
      RI_RAW:        rdData = 32'(rawIntr);
      RI_MASKED:     rdData = 32'(rawIntr & maskReg);
      RI_STREAM:     rdData = 32'(streamReg);
      default:       rdData = '0;
    endcase
  end

  assign irq     = |(rawIntr & maskReg);
  assign chState = stateQ;

endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
  import dma_regfront_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  parameter int SRC_W  = 4,
  parameter int INTR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [1:0]            busSize,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  output logic                  errFlag,
  input  logic [NCH-1:0]        hasClient,
  input  logic [NCH-1:0]        descEol,
  input  logic [NCH-1:0]        eolHit,
  input  logic [NCH*INTR_W-1:0] intrSet,
  input  logic [NCH*SRC_W-1:0]  cmdSrc,
  output logic [NCH-1:0]        chanIrq,
  output logic [NCH-1:0]        startStb,
  output logic [NCH-1:0]        contStb,
  output logic [NCH-1:0]        loadDescStb,
  output logic [NCH-1:0]        loadCtxStb
);

  localparam int CH_W = ADDR_W - 13;

  wrStrobe_t            wrStb;
  logic [NCH-1:0]       chanHit;
  logic [REG_IDX_W-1:0] regIdx;
  logic [CH_W-1:0]      chanIdx;
  logic                 rdEn;
  logic [31:0]          chRd [NCH];
  logic [NCH*3-1:0]     chStateFlat;

  dma_regfront_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .wrStb(wrStb), .chanHit(chanHit),
    .regIdx(regIdx), .chanIdx(chanIdx), .rdEn(rdEn), .errFlag(errFlag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dma_regfront_chan #(.SRC_W(SRC_W), .INTR_W(INTR_W)) u_chan (
      .clk(clk), .rstN(rstN), .sel(chanHit[i]), .wrStb(wrStb),
      .wdata(busWdata), .regIdx(regIdx), .hasClient(hasClient[i]),
      .descEol(descEol[i]), .eolHit(eolHit[i]),
      .intrSet(intrSet[i*INTR_W +: INTR_W]), .cmdSrc(cmdSrc[i*SRC_W +: SRC_W]),
      .rdData(chRd[i]), .irq(chanIrq[i]), .startStb(startStb[i]),
      .contStb(contStb[i]), .loadDescStb(loadDescStb[i]),
      .loadCtxStb(loadCtxStb[i]), .chState(chStateFlat[i*3 +: 3])
    );
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rdEn && chanIdx == CH_W'(i)) busRdata = chRd[i];
    end
  end

endmodule

// File: rtl/dma_regfront_chk.sv
module dma_regfront_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  parameter int INTR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [31:0]       busWdata,
  input logic              errFlag,
  input logic [NCH-1:0]    descEol,
  input logic [NCH-1:0]    chanIrq,
  input logic [NCH-1:0]    startStb,
  input logic [NCH-1:0]    contStb,
  input logic [NCH*3-1:0]  chStateFlat
);

  localparam int CH_W = ADDR_W - 13;

  logic unusedWdata;
  assign unusedWdata = ^busWdata[31:INTR_W];

  // R10: a wrong-width access raises the error flag, which then stays set
  p_bad_size_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSize != 2'b10) |=> errFlag);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R4: the state code is always one of the three one-hot values
    p_state_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(chStateFlat[i*3 +: 3]));
    // R7: a start strobe coincides with the running state
    p_start_running_r7: assert property (@(posedge clk) disable iff (!rstN)
      startStb[i] |-> chStateFlat[i*3 +: 3] == 3'b100);
    // R8: a continue needs an end-of-list descriptor at the write edge
    p_cont_eol_r8: assert property (@(posedge clk) disable iff (!rstN)
      contStb[i] |-> $past(descEol[i]));
    // R6: writing an all-zero mask silences the line on the next cycle
    p_mask_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && busWrite && busSize == 2'b10
       && busAddr[ADDR_W-1:13] == CH_W'(i) && busAddr[7:2] == 6'd5
       && busWdata[INTR_W-1:0] == '0) |=> !chanIrq[i]);
  end

endmodule

bind dma_regfront dma_regfront_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .INTR_W(INTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .errFlag(errFlag),
  .descEol(descEol), .chanIrq(chanIrq), .startStb(startStb), .contStb(contStb),
  .chStateFlat(chStateFlat)
);

// File: tb/tb_dma_regfront.sv
module tb_dma_regfront;

  localparam int NCH = 3;
  localparam int ADDR_W = 16;
  localparam int SRC_W = 4;
  localparam int INTR_W = 4;

  localparam int R_CFG = 0, R_CMD = 1, R_STAT = 2, R_SDESC = 3, R_SBUF = 4;
  localparam int R_MASK = 5, R_ACK = 6, R_RAW = 7, R_MSKD = 8, R_STRM = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0] busSize = 2'b10;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic errFlag;
  logic [NCH-1:0] hasClient = '0, descEol = '0, eolHit = '0;
  logic [NCH*INTR_W-1:0] intrSet = '0;
  logic [NCH*SRC_W-1:0] cmdSrc = '0;
  logic [NCH-1:0] chanIrq, startStb, contStb, loadDescStb, loadCtxStb;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  dma_regfront #(.NCH(NCH), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .INTR_W(INTR_W)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .errFlag(errFlag), .hasClient(hasClient),
    .descEol(descEol), .eolHit(eolHit), .intrSet(intrSet), .cmdSrc(cmdSrc),
    .chanIrq(chanIrq), .startStb(startStb), .contStb(contStb),
    .loadDescStb(loadDescStb), .loadCtxStb(loadCtxStb)
  );

  function automatic logic [ADDR_W-1:0] adr(int ch, int r);
    return ADDR_W'((ch << 13) | (r << 2));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobes of this write are visible when the task returns
  task automatic wr(int ch, int r, logic [31:0] d, logic [1:0] sz = 2'b10);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = adr(ch, r);
    busWdata = d; busSize = sz;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busSize = 2'b10;
  endtask

  task automatic rdReg(int ch, int r, output logic [31:0] d, input logic [1:0] sz = 2'b10);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = adr(ch, r); busSize = sz;
    #1 d = busRdata;
    @(posedge clk);
    #1 busValid = 1'b0; busSize = 2'b10;
  endtask

  task automatic testReset();
    rdReg(0, R_STAT, rd); chk("R2 status", rd, 32'h1);
    rdReg(1, R_RAW, rd);  chk("R2 raw", rd, 32'h0);
    rdReg(2, R_CFG, rd);  chk("R2 cfg", rd, 32'h0);
    chk("R2 irq/err/strobes",
        {chanIrq, startStb, contStb, loadDescStb, loadCtxStb, errFlag}, 32'h0);
  endtask

  task automatic testSavedPtrs();
    wr(1, R_SDESC, 32'hDEADBEEF);
    wr(2, R_SBUF, 32'h12345678);
    rdReg(1, R_SDESC, rd); chk("R1 saved desc", rd, 32'hDEADBEEF);
    rdReg(2, R_SBUF, rd);  chk("R1 saved buf", rd, 32'h12345678);
    rdReg(0, R_SDESC, rd); chk("R1 other channel untouched", rd, 32'h0);
    rdReg(1, 20, rd);      chk("R1 unmapped index", rd, 32'h0);
  endtask

  task automatic testOutOfRange();
    wr(3, R_SDESC, 32'hCAFE0001);
    rdReg(3, R_SDESC, rd); chk("R11 ch3 reads zero", rd, 32'h0);
    wr(7, R_SBUF, 32'h55AA55AA);
    rdReg(7, R_SBUF, rd);  chk("R11 ch7 reads zero", rd, 32'h0);
    rdReg(0, R_SBUF, rd);  chk("R11 no alias into ch0", rd, 32'h0);
    chk("R11 no error flag", 32'(errFlag), 32'h0);
  endtask

  task automatic testStartAndCfg();
    hasClient[0] = 1'b1;
    wr(0, R_CFG, 32'h1);
    rdReg(0, R_STAT, rd); chk("R3 enable keeps reset state", rd, 32'h1);
    wr(0, R_STRM, 32'h3);
    chk("R7 start strobe", 32'(startStb), 32'h1);
    chk("R7 load desc strobe", 32'(loadDescStb), 32'h1);
    rdReg(0, R_STAT, rd); chk("R7 running", rd, 32'h4);
    chk("R7 strobes one cycle", 32'(startStb | loadDescStb), 32'h0);
    wr(0, R_CFG, 32'h3);
    rdReg(0, R_STAT, rd); chk("R3 stop", rd, 32'h2);
    wr(0, R_CFG, 32'h2);
    rdReg(0, R_STAT, rd); chk("R3 reset wins over stop", rd, 32'h1);
    // no client on ch1: fetch strobes but no start
    wr(1, R_STRM, 32'h000FFFF7);
    chk("R7 no start without client", 32'(startStb), 32'h0);
    chk("R7 load desc+ctx ch1", 32'({loadDescStb, loadCtxStb}), 32'b010_010);
    rdReg(1, R_STRM, rd); chk("R7 low 10 bits kept", rd, 32'h3F7);
    rdReg(1, R_STAT, rd); chk("R7 ch1 stays reset", rd, 32'h1);
    wr(2, R_STRM, 32'h4);
    chk("R7 ctx only", 32'({loadDescStb, loadCtxStb}), 32'b000_100);
  endtask

  task automatic testContinue();
    cmdSrc[3:0] = 4'hA;
    wr(0, R_CFG, 32'h1);
    wr(0, R_STRM, 32'h3);
    descEol[0] = 1'b1;
    wr(0, R_CMD, 32'h1);
    chk("R8 no continue before end of list", 32'(contStb), 32'h0);
    @(negedge clk); eolHit[0] = 1'b1;
    @(negedge clk); eolHit[0] = 1'b0;
    rdReg(0, R_STAT, rd); chk("R9/R4 status with eol and source", rd, 32'hA24);
    descEol[0] = 1'b0;
    wr(0, R_CMD, 32'h1);
    chk("R8 no continue without descEol", 32'(contStb), 32'h0);
    descEol[0] = 1'b1;
    wr(0, R_CMD, 32'h0);
    chk("R8 bit0 clear no continue", 32'(contStb), 32'h0);
    hasClient[0] = 1'b0;
    wr(0, R_CMD, 32'h1);
    chk("R8 no continue without client", 32'(contStb), 32'h0);
    hasClient[0] = 1'b1;
    wr(0, R_CMD, 32'h1);
    chk("R8 continue", 32'(contStb), 32'h1);
    rdReg(0, R_STAT, rd); chk("R8 eol cleared", rd, 32'hA04);
    rdReg(0, R_CMD, rd);  chk("R1 cmd readback", rd, 32'h1);
  endtask

  task automatic testIntr();
    @(negedge clk); intrSet[11:8] = 4'b0101;
    @(negedge clk); intrSet[11:8] = 4'b0000;
    rdReg(2, R_RAW, rd);  chk("R5 raw set", rd, 32'h5);
    chk("R6 irq low with zero mask", 32'(chanIrq), 32'h0);
    wr(2, R_MASK, 32'h4);
    chk("R6 irq high", 32'(chanIrq), 32'h4);
    rdReg(2, R_MSKD, rd); chk("R6 masked", rd, 32'h4);
    wr(2, R_ACK, 32'h4);
    rdReg(2, R_RAW, rd);  chk("R5 ack clears", rd, 32'h1);
    chk("R6 irq drops after ack", 32'(chanIrq), 32'h0);
    rdReg(2, R_ACK, rd);  chk("R5 ack reads zero", rd, 32'h0);
    // set and acknowledge of the same bit in one cycle
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = adr(2, R_ACK);
    busWdata = 32'h4; intrSet[11:8] = 4'b0100;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; intrSet[11:8] = 4'b0000;
    rdReg(2, R_RAW, rd);  chk("R5 set beats ack", rd, 32'h5);
    chk("R6 irq back on", 32'(chanIrq), 32'h4);
  endtask

  task automatic testBadSize();
    wr(1, R_SDESC, 32'h11111111, 2'b01);
    chk("R10 error flag set", 32'(errFlag), 32'h1);
    rdReg(1, R_SDESC, rd); chk("R10 write ignored", rd, 32'hDEADBEEF);
    rdReg(1, R_SDESC, rd, 2'b00); chk("R10 narrow read zero", rd, 32'h0);
    chk("R10 flag sticky", 32'(errFlag), 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testSavedPtrs();
    testOutOfRange();
    testStartAndCfg();
    testContinue();
    testIntr();
    testBadSize();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule